// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block models how a processor core takes a normal or fast interrupt. It holds the live status word and the program counter. It also holds two banks of shadow registers, one per interrupt class. Each bank has a link register for the return address and a saved copy of the status word. In every clock cycle the unit picks exactly one event and applies it. The possible events are: a return, a software write of the status word, a fast entry, a normal entry, or a plain advance of the program counter to the value on a stub input.

A request is taken only while its own mask bit in the status word is clear. The normal mask is bit 7 (value 0x80) and the fast mask is bit 6 (value 0x40). The mode field is bits 4:0.

On entry the unit does four things:
- It copies the old status word into the saved-status register of the new mode.
- It copies the stub next-instruction address into that mode's link register.
- It writes the new mode code and sets the mask bits.
- It forces the program counter to the fixed vector.

A one-cycle return pulse undoes an entry. The controlling software clears the mask bits through the status write port, and the return pulse models the return from the handler.

Top module: `exc_entry_unit`

## Requirements
- R1: While reset is asserted and right after it, the status word is 0x000000D3: mode field 5'b10011, bits 7 and 6 set, every other bit zero. The program counter and all four bank registers are zero.
- R2: In a cycle with no return, no write and no taken request, the program counter loads `pc_adv_i` and the status word keeps its value.
- R3: When `stat_wr_i` is high and there is no return, the whole status word loads `stat_wdata_i` and the program counter loads `pc_adv_i`.
- R4: A normal request taken while bit 7 is clear gives, one cycle later: program counter 0x18, mode field 5'b10010, bit 7 set, and all other status bits unchanged.
- R5: A fast request taken while bit 6 is clear gives, one cycle later: program counter 0x1C, mode field 5'b10001, bits 6 and 7 set, and all other status bits unchanged.
- R6: A normal request while bit 7 is set, or a fast request while bit 6 is set, has no effect. The program counter advances and the status word and bank registers stay unchanged.
- R7: When both requests are taken in the same cycle, the fast entry is performed.
- R8: On entry, the link register of the new mode receives `pc_adv_i` and its saved-status register receives the status word from before the entry. The other bank is left unchanged.
- R9: A return pulse in mode 5'b10010 or 5'b10001 loads the status word from that mode's saved-status register and the program counter from that mode's link register. In any other mode, a return pulse only advances the program counter.
- R10: Within one cycle the priority is: return, then status write, then fast request, then normal request. An event that loses does nothing in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 1 | Normal interrupt request level |
| fiq_i | input | 1 | Fast interrupt request level |
| ret_i | input | 1 | One-cycle return-from-exception pulse |
| stat_wr_i | input | 1 | Status word write strobe |
| stat_wdata_i | input | STAT_W | Status word write data |
| pc_adv_i | input | ADDR_W | Stub next-instruction address |
| pc_o | output | ADDR_W | Program counter |
| stat_o | output | STAT_W | Live status word |
| link_nrm_o | output | ADDR_W | Normal-mode link register |
| sstat_nrm_o | output | STAT_W | Normal-mode saved status |
| link_fst_o | output | ADDR_W | Fast-mode link register |
| sstat_fst_o | output | STAT_W | Fast-mode saved status |

## Verification
Each piece of state is a port, so a wrong mask bit, mode code or bank value shows up at the outputs one cycle after the faulty event. It then stays wrong until a later write or return overwrites it. A corrupted saved-status or link register stays hidden in the status word and program counter until the matching return pulse. The reference model catches it even earlier, because it compares the bank ports on every cycle. Nesting, where a fast entry interrupts a normal handler and then two returns follow, exercises both banks together, so a swap between the banks shows up at the ports.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   localparam logic [4:0] MODE_SUP = 5'b10011;
   localparam logic [4:0] MODE_NRM = 5'b10010;
   localparam logic [4:0] MODE_FST = 5'b10001;

   localparam int BIT_NMASK = 7;
   localparam int BIT_FMASK = 6;
   localparam int MODE_W    = 5;

   // Exception kinds in vector order: each vector is its kind times four.
   typedef enum logic [2:0] {
      VK_RESET, VK_UNDEF, VK_SWI, VK_PABT, VK_DABT, VK_RSVD, VK_NRM, VK_FST
   } vec_kind_e;

   typedef enum logic [2:0] {
      EV_ADV, EV_RET, EV_WRITE, EV_FAST, EV_NORM
   } exc_event_e;

   function automatic logic [4:0] vec_offset(vec_kind_e k);
      return {k, 2'b00};
   endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_entry_pkg::*;
(
   input  logic       irq_i,
   input  logic       fiq_i,
   input  logic       ret_i,
   input  logic       wr_i,
   input  logic       nmask_i,
   input  logic       fmask_i,
   output exc_event_e ev_o
);

   always_comb begin
      if (ret_i)                  ev_o = EV_RET;
      else if (wr_i)              ev_o = EV_WRITE;
      else if (fiq_i && !fmask_i) ev_o = EV_FAST;
      else if (irq_i && !nmask_i) ev_o = EV_NORM;
      else                        ev_o = EV_ADV;
   end

   // R7 / R10: taken fast request never yields to a normal one
   always_comb begin
      if (!ret_i && !wr_i && fiq_i && !fmask_i)
         assert_fast_wins_R7: assert (ev_o == EV_FAST);
   end

endmodule

// File: rtl/exc_bank.sv
module exc_bank #(
   parameter int ADDR_W = 32,
   parameter int STAT_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              save_i,
   input  logic [ADDR_W-1:0] link_d_i,
   input  logic [STAT_W-1:0] stat_d_i,
   output logic [ADDR_W-1:0] link_q_o,
   output logic [STAT_W-1:0] stat_q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_q_o <= '0;
         stat_q_o <= '0;
      end else if (save_i) begin
         link_q_o <= link_d_i;
         stat_q_o <= stat_d_i;
      end
   end

   // R8: bank content changes only in a save cycle
   assert_bank_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !save_i |=> ($stable(link_q_o) && $stable(stat_q_o)));

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_entry_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int STAT_W    = 32,
   parameter int REQ_STAGE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_i,
   input  logic              fiq_i,
   input  logic              ret_i,
   input  logic              stat_wr_i,
   input  logic [STAT_W-1:0] stat_wdata_i,
   input  logic [ADDR_W-1:0] pc_adv_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [STAT_W-1:0] stat_o,
   output logic [ADDR_W-1:0] link_nrm_o,
   output logic [STAT_W-1:0] sstat_nrm_o,
   output logic [ADDR_W-1:0] link_fst_o,
   output logic [STAT_W-1:0] sstat_fst_o
);

   localparam int NBANK = 2;
   localparam int B_NRM = 0;
   localparam int B_FST = 1;
   localparam logic [STAT_W-1:0] STAT_RST =
      STAT_W'(MODE_SUP) | (STAT_W'(1) << BIT_NMASK) | (STAT_W'(1) << BIT_FMASK);
   localparam logic [ADDR_W-1:0] PC_RST = ADDR_W'(vec_offset(VK_RESET));
   localparam logic [ADDR_W-1:0] PC_NRM = ADDR_W'(vec_offset(VK_NRM));
   localparam logic [ADDR_W-1:0] PC_FST = ADDR_W'(vec_offset(VK_FST));

   if (STAT_W < 8 || ADDR_W < 5) begin : g_bad_param
      initial $fatal(1, "exc_entry_unit: STAT_W must be >= 8 and ADDR_W >= 5");
   end
   if (REQ_STAGE != 0 && REQ_STAGE != 1) begin : g_bad_stage
      initial $fatal(1, "exc_entry_unit: REQ_STAGE must be 0 or 1");
   end

   logic irq_s, fiq_s;

   if (REQ_STAGE == 1) begin : g_req_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_s <= 1'b0;
            fiq_s <= 1'b0;
         end else begin
            irq_s <= irq_i;
            fiq_s <= fiq_i;
         end
      end
   end else begin : g_req_direct
      assign irq_s = irq_i;
      assign fiq_s = fiq_i;
   end

   logic [STAT_W-1:0] stat_q;
   logic [ADDR_W-1:0] pc_q;
   exc_event_e        ev;

   exc_arbiter i_arb (
      .irq_i   (irq_s),
      .fiq_i   (fiq_s),
      .ret_i   (ret_i),
      .wr_i    (stat_wr_i),
      .nmask_i (stat_q[BIT_NMASK]),
      .fmask_i (stat_q[BIT_FMASK]),
      .ev_o    (ev)
   );

   logic [NBANK-1:0]  bank_save;
   logic [ADDR_W-1:0] bank_link [NBANK];
   logic [STAT_W-1:0] bank_stat [NBANK];

   assign bank_save[B_NRM] = (ev == EV_NORM);
   assign bank_save[B_FST] = (ev == EV_FAST);

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      exc_bank #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) i_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .save_i   (bank_save[b]),
         .link_d_i (pc_adv_i),
         .stat_d_i (stat_q),
         .link_q_o (bank_link[b]),
         .stat_q_o (bank_stat[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= STAT_RST;
         pc_q   <= PC_RST;
      end else begin
         unique case (ev)
            EV_RET: begin
               if (stat_q[MODE_W-1:0] == MODE_NRM) begin
                  stat_q <= bank_stat[B_NRM];
                  pc_q   <= bank_link[B_NRM];
               end else if (stat_q[MODE_W-1:0] == MODE_FST) begin
                  stat_q <= bank_stat[B_FST];
                  pc_q   <= bank_link[B_FST];
               end else begin
                  pc_q   <= pc_adv_i;
               end
            end
            EV_WRITE: begin
               stat_q <= stat_wdata_i;
               pc_q   <= pc_adv_i;
            end
            EV_FAST: begin
               stat_q[MODE_W-1:0] <= MODE_FST;
               stat_q[BIT_NMASK]  <= 1'b1;
               stat_q[BIT_FMASK]  <= 1'b1;
               pc_q               <= PC_FST;
            end
            EV_NORM: begin
               stat_q[MODE_W-1:0] <= MODE_NRM;
               stat_q[BIT_NMASK]  <= 1'b1;
               pc_q               <= PC_NRM;
            end
            default: pc_q <= pc_adv_i;
         endcase
      end
   end

   assign pc_o        = pc_q;
   assign stat_o      = stat_q;
   assign link_nrm_o  = bank_link[B_NRM];
   assign sstat_nrm_o = bank_stat[B_NRM];
   assign link_fst_o  = bank_link[B_FST];
   assign sstat_fst_o = bank_stat[B_FST];

   // R4: normal entry lands on its vector with its mode and mask
   assert_norm_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ret_i && !stat_wr_i && !(fiq_s && !stat_o[BIT_FMASK]) && irq_s && !stat_o[BIT_NMASK])
      |=> (pc_o == PC_NRM && stat_o[MODE_W-1:0] == MODE_NRM && stat_o[BIT_NMASK]
           && stat_o[BIT_FMASK] == $past(stat_o[BIT_FMASK])));

   // R5: fast entry lands on its vector and masks both classes
   assert_fast_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ret_i && !stat_wr_i && fiq_s && !stat_o[BIT_FMASK])
      |=> (pc_o == PC_FST && stat_o[MODE_W-1:0] == MODE_FST
           && stat_o[BIT_NMASK] && stat_o[BIT_FMASK]));

   // R6: masked requests leave the status word alone
   assert_masked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ret_i && !stat_wr_i && stat_o[BIT_NMASK] && stat_o[BIT_FMASK])
      |=> ($stable(stat_o) && pc_o == $past(pc_adv_i)));

   // R8: entry captures the old status and the next address
   assert_entry_save_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ret_i && !stat_wr_i && fiq_s && !stat_o[BIT_FMASK])
      |=> (sstat_fst_o == $past(stat_o) && link_fst_o == $past(pc_adv_i)));

   // R9: return from normal mode restores from the normal bank
   assert_norm_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && stat_o[MODE_W-1:0] == MODE_NRM)
      |=> (stat_o == $past(sstat_nrm_o) && pc_o == $past(link_nrm_o)));

   // R3: status write takes the whole word
   assert_stat_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ret_i && stat_wr_i) |=> (stat_o == $past(stat_wdata_i)));

endmodule

// File: tb/test_exc_entry_unit.sv
module test_exc_entry_unit;

   localparam int AW = 32;
   localparam int SW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          irq = 1'b0, fiq = 1'b0, ret = 1'b0, wr = 1'b0;
   logic [SW-1:0] wdata = '0;
   logic [AW-1:0] padv = '0;
   logic [AW-1:0] pc_o, link_nrm_o, link_fst_o;
   logic [SW-1:0] stat_o, sstat_nrm_o, sstat_fst_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference state
   logic [AW-1:0] m_pc, m_ln, m_lf;
   logic [SW-1:0] m_st, m_sn, m_sf;

   always #5 clk = ~clk;

   exc_entry_unit i_exc_entry_unit (
      .clk(clk), .rst_n(rst_n), .irq_i(irq), .fiq_i(fiq), .ret_i(ret),
      .stat_wr_i(wr), .stat_wdata_i(wdata), .pc_adv_i(padv),
      .pc_o(pc_o), .stat_o(stat_o), .link_nrm_o(link_nrm_o),
      .sstat_nrm_o(sstat_nrm_o), .link_fst_o(link_fst_o), .sstat_fst_o(sstat_fst_o)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic cmp_all(string tag);
      chk(tag, "pc", pc_o, m_pc);
      chk(tag, "stat", stat_o, m_st);
      chk(tag, "link_nrm", link_nrm_o, m_ln);
      chk(tag, "sstat_nrm", sstat_nrm_o, m_sn);
      chk(tag, "link_fst", link_fst_o, m_lf);
      chk(tag, "sstat_fst", sstat_fst_o, m_sf);
   endtask

   task automatic model_reset();
      m_pc = 32'h0; m_st = 32'h0000_00D3;
      m_ln = '0; m_lf = '0; m_sn = '0; m_sf = '0;
   endtask

   // behavioural reference: one event per clock, priority ret > write > fast > normal
   task automatic model_edge();
      if (ret) begin
         if (m_st[4:0] == 5'h12) begin m_st = m_sn; m_pc = m_ln; end
         else if (m_st[4:0] == 5'h11) begin m_st = m_sf; m_pc = m_lf; end
         else m_pc = padv;
      end else if (wr) begin
         m_st = wdata; m_pc = padv;
      end else if (fiq && m_st[6] == 1'b0) begin
         m_sf = m_st; m_lf = padv;
         m_st = {m_st[31:8], 2'b11, m_st[5], 5'h11};
         m_pc = 32'h1C;
      end else if (irq && m_st[7] == 1'b0) begin
         m_sn = m_st; m_ln = padv;
         m_st = {m_st[31:8], 1'b1, m_st[6:5], 5'h12};
         m_pc = 32'h18;
      end else begin
         m_pc = padv;
      end
   endtask

   task automatic step(bit i_irq, bit i_fiq, bit i_ret, bit i_wr,
                       logic [31:0] i_wd, logic [31:0] i_pa, string tag);
      irq = i_irq; fiq = i_fiq; ret = i_ret; wr = i_wr; wdata = i_wd; padv = i_pa;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      cmp_all(tag);
   endtask

   initial begin
      #1ms;
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      model_reset();
      @(posedge clk);
      @(negedge clk);
      cmp_all("R1 in reset");
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      model_edge();
      cmp_all("R1 after reset");

      step(0, 0, 0, 0, 0, 32'h104, "R2 advance");
      step(0, 0, 0, 0, 0, 32'h1234, "R2 advance");
      step(1, 0, 0, 0, 0, 32'h108, "R6 normal masked");
      step(0, 1, 0, 0, 0, 32'h10C, "R6 fast masked");
      step(1, 1, 0, 0, 0, 32'h110, "R6 both masked");
      step(0, 0, 0, 1, 32'hA000_0013, 32'h114, "R3 write clears masks");
      step(1, 0, 0, 0, 0, 32'h118, "R4 normal entry R8");
      chk("R4", "pc vector", pc_o, 32'h18);
      chk("R8", "link_nrm", link_nrm_o, 32'h118);
      chk("R8", "sstat_nrm", sstat_nrm_o, 32'hA000_0013);
      step(1, 0, 0, 0, 0, 32'h11C, "R6 normal masked in handler");
      step(0, 1, 0, 0, 0, 32'h120, "R5 nested fast entry R8");
      chk("R5", "stat", stat_o, 32'hA000_00D1);
      chk("R8", "sstat_fst", sstat_fst_o, 32'hA000_0092);
      step(0, 1, 0, 0, 0, 32'h124, "R6 fast masked in handler");
      step(0, 0, 1, 0, 0, 32'h128, "R9 return from fast");
      chk("R9", "pc from link_fst", pc_o, 32'h120);
      step(0, 0, 1, 0, 0, 32'h12C, "R9 return from normal");
      chk("R9", "stat restored", stat_o, 32'hA000_0013);
      step(1, 1, 0, 0, 0, 32'h130, "R7 both taken fast wins");
      chk("R7", "pc", pc_o, 32'h1C);
      step(0, 0, 1, 0, 0, 32'h134, "R9 return");
      step(0, 0, 0, 1, 32'h0000_00D3, 32'h138, "R3 write supervisor masked");
      step(0, 0, 1, 0, 0, 32'h13C, "R9 return ignored in supervisor");
      chk("R9", "pc advanced", pc_o, 32'h13C);
      step(0, 0, 0, 1, 32'h0000_0013, 32'h140, "R3 unmask");
      step(1, 1, 0, 1, 32'h0000_00D3, 32'h144, "R10 write beats requests");
      chk("R10", "stat", stat_o, 32'h0000_00D3);
      step(0, 0, 0, 1, 32'h0000_0013, 32'h148, "R3 unmask");
      step(1, 0, 0, 0, 0, 32'h14C, "R4 entry");
      step(0, 1, 1, 1, 32'h5, 32'h150, "R10 return beats write and fast");
      chk("R10", "pc", pc_o, 32'h14C);

      lfsr = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
         logic [31:0] wd;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (lfsr[9:8])
            2'd0: wd = {lfsr, 8'h0, lfsr[7:6], 1'b0, 5'h13};
            2'd1: wd = {lfsr, 8'h0, lfsr[7:6], 1'b1, 5'h12};
            2'd2: wd = {lfsr, 8'h0, lfsr[7:6], 1'b0, 5'h11};
            default: wd = {16'h0, lfsr};
         endcase
         step(lfsr[0], lfsr[1], lfsr[2] & lfsr[3], lfsr[4] & lfsr[5] & ~lfsr[11],
              wd, {lfsr, lfsr} & 32'hFFFF_FFFC, "R10 mixed traffic");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule